// File: doc/BRIEF.md
# Circular Sample Buffer Window Controller

This block manages one ring of 16-bit samples that lives inside a shared 256-word memory. Software places the ring by giving a start address and a length of 1 to 255 words. A producer pushes words, and each accepted push becomes a write strobe at the start address plus a wrapping write index. A consumer pulls words, and each accepted pull becomes a read strobe at the start address plus a wrapping read index. The word that comes back is held on `rd_data`. Physical addresses wrap modulo 256, so a ring may straddle the top of the memory. The memory array and any arithmetic on the samples sit outside the block.

An occupancy count runs beside the two indices. Two level flags come from it and trip early: `full_flag` rises when fewer than T free slots remain, and `empty_flag` rises when fewer than T unread words remain. T is 1, 2, 4 or 8, chosen by a 2-bit code. A push into a ring with no free slot and a pull from a ring with no unread word are refused, and each sets its own sticky error. The flags drive two DMA requests and one interrupt line, each gated by its own enable. A one-cycle clear pulse empties the ring and clears both errors.

Top module: `circ_buf_window`

## Requirements
- R1: After `rst_n` is released, the count and both indices are 0. `ovf_flag`, `unf_flag`, `clr_busy` and `rd_data` are 0, and `empty_flag` is 1.
- R2: A push is accepted when the count is below `cfg_len`. In that cycle `mem_wr_en` is 1, `mem_wr_addr` = (`cfg_base` + write index) mod 256 and `mem_wr_data` = `wr_data`. In every other cycle `mem_wr_en` is 0.
- R3: Each index advances by one per accepted access and returns from `cfg_len`-1 to 0. The count rises by 1 per accepted push, falls by 1 per accepted pull, and never exceeds `cfg_len`.
- R4: With T = 2^`cfg_wm` (code 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8), `full_flag` is 1 exactly while `cfg_len` minus the count is less than T.
- R5: `empty_flag` is 1 exactly while the count is less than T.
- R6: A push while the count equals `cfg_len` writes nothing and leaves the indices and count unchanged. It sets `ovf_flag`, which then stays at 1 until a clear.
- R7: A pull while the count is 0 issues no `mem_rd_en` and leaves `rd_data` unchanged. It sets `unf_flag`, which then stays at 1 until a clear.
- R8: A pull is accepted when the count is above 0. In that cycle `mem_rd_en` is 1 and `mem_rd_addr` = (`cfg_base` + read index) mod 256. After the next rising edge, `rd_data` holds the word stored at that address.
- R9: A one-cycle pulse on `soft_clr` raises `clr_busy` for exactly one cycle. In that cycle pushes and pulls are ignored. At the edge that ends that cycle, the indices, the count and both errors return to 0.
- R10: `dma_wr_req` = `dma_wr_en` AND NOT `full_flag`. `dma_rd_req` = `dma_rd_en` AND NOT `empty_flag`.
- R11: `irq` is the OR of four terms. Bit 0 of `irq_en` gates `ovf_flag`, bit 1 gates `unf_flag`, bit 2 gates NOT `full_flag`, and bit 3 gates NOT `empty_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 8 | First memory word of the ring |
| cfg_len | input | 8 | Ring length in words, 1 to 255 |
| cfg_wm | input | 2 | Threshold code, T = 2^code |
| soft_clr | input | 1 | One-cycle clear request |
| wr_en | input | 1 | Producer push |
| wr_data | input | 16 | Word to push |
| rd_en | input | 1 | Consumer pull |
| rd_data | output | 16 | Last word pulled |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | 8 | Memory write address |
| mem_wr_data | output | 16 | Memory write data |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 8 | Memory read address |
| mem_rd_data | input | 16 | Memory read data, valid in the same cycle as the address |
| dma_wr_en | input | 1 | Enable for the write DMA request |
| dma_rd_en | input | 1 | Enable for the read DMA request |
| irq_en | input | 4 | Interrupt enables, bit mapping as in R11 |
| full_flag | output | 1 | Early-threshold full flag |
| empty_flag | output | 1 | Early-threshold empty flag |
| ovf_flag | output | 1 | Sticky overflow error |
| unf_flag | output | 1 | Sticky underflow error |
| dma_wr_req | output | 1 | Write DMA request |
| dma_rd_req | output | 1 | Read DMA request |
| irq | output | 1 | Combined interrupt |
| clr_busy | output | 1 | Clear in progress |

## Verification
Several results settle in the same cycle as the stimulus or the registered state that causes them, with no clock edge in between: the memory strobes, addresses and write data, the two level flags, the DMA requests and `irq`. Other results settle one rising edge after the cycle that caused them: `rd_data` after an accepted pull, the error flags after a refused access, and `clr_busy` after the `soft_clr` pulse. The state cleared by that clear returns to 0 at the second edge after the pulse. The bench changes inputs at the falling edge and compares all outputs 1 ns later against a cycle model. Each registered effect is applied to the model in the call that drives its cause, so the comparison for it falls in the following cycle.

// File: rtl/circ_buf_window.sv
module circ_buf_window #(
  parameter int DW  = 16,
  parameter int AW  = 8,
  parameter int WMW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_len,
  input  logic [WMW-1:0] cfg_wm,
  input  logic          soft_clr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data,
  input  logic          dma_wr_en,
  input  logic          dma_rd_en,
  input  logic [3:0]    irq_en,
  output logic          full_flag,
  output logic          empty_flag,
  output logic          ovf_flag,
  output logic          unf_flag,
  output logic          dma_wr_req,
  output logic          dma_rd_req,
  output logic          irq,
  output logic          clr_busy
);
  localparam int CW = AW + 1;

  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, len_x, thr, room;
  logic          clr_q, ovf_q, unf_q;
  logic [DW-1:0] rd_q;
  logic          wr_ok, wr_bad, rd_ok, rd_bad;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p, input logic [AW-1:0] n);
    return (p == n - 1'b1) ? '0 : p + 1'b1;
  endfunction

  assign len_x  = {1'b0, cfg_len};
  assign thr    = CW'(1) << cfg_wm;
  assign room   = len_x - cnt;

  assign wr_ok  = wr_en & ~clr_q & (cnt != len_x);
  assign wr_bad = wr_en & ~clr_q & (cnt == len_x);
  assign rd_ok  = rd_en & ~clr_q & (cnt != '0);
  assign rd_bad = rd_en & ~clr_q & (cnt == '0);

  assign mem_wr_en   = wr_ok;
  assign mem_wr_addr = cfg_base + wp;
  assign mem_wr_data = wr_data;
  assign mem_rd_en   = rd_ok;
  assign mem_rd_addr = cfg_base + rp;

  assign full_flag  = room < thr;
  assign empty_flag = cnt < thr;
  assign ovf_flag   = ovf_q;
  assign unf_flag   = unf_q;
  assign rd_data    = rd_q;
  assign clr_busy   = clr_q;

  assign dma_wr_req = dma_wr_en & ~full_flag;
  assign dma_rd_req = dma_rd_en & ~empty_flag;
  assign irq = (irq_en[0] & ovf_q) | (irq_en[1] & unf_q) |
               (irq_en[2] & ~full_flag) | (irq_en[3] & ~empty_flag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      clr_q <= 1'b0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      clr_q <= soft_clr & ~clr_q;
      if (clr_q) begin
        wp    <= '0;
        rp    <= '0;
        cnt   <= '0;
        ovf_q <= 1'b0;
        unf_q <= 1'b0;
      end else begin
        if (wr_ok) wp <= bump(wp, cfg_len);
        if (rd_ok) begin
          rp   <= bump(rp, cfg_len);
          rd_q <= mem_rd_data;
        end
        cnt <= cnt + CW'(wr_ok) - CW'(rd_ok);
        if (wr_bad) ovf_q <= 1'b1;
        if (rd_bad) unf_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/circ_buf_window_chk.sv
module circ_buf_window_chk #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] cfg_base,
  input logic [AW-1:0] cfg_len,
  input logic          wr_en,
  input logic [DW-1:0] rd_data,
  input logic          mem_wr_en,
  input logic [AW-1:0] mem_wr_addr,
  input logic          full_flag,
  input logic          empty_flag,
  input logic          ovf_flag,
  input logic          unf_flag,
  input logic          dma_wr_req,
  input logic          dma_rd_req,
  input logic          clr_busy,
  input logic [AW:0]   cnt
);
  logic [AW-1:0] wr_off;
  assign wr_off = mem_wr_addr - cfg_base;

  assert_wr_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> wr_off < cfg_len);

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= {1'b0, cfg_len});

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_busy) |=> ovf_flag);

  assert_no_overflow_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(wr_en) && !$past(mem_wr_en)));

  assert_unf_keeps_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unf_flag) |-> $stable(rd_data));

  assert_clear_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |=> (!clr_busy && !ovf_flag && !unf_flag && cnt == '0));

  assert_dma_wr_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_wr_req |-> !full_flag);

  assert_dma_rd_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rd_req |-> !empty_flag);
endmodule

bind circ_buf_window circ_buf_window_chk #(.DW(DW), .AW(AW)) chk_i (.*);

// File: tb/circ_buf_window_tb_top.sv
module circ_buf_window_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_base = 8'd0, cfg_len = 8'd8;
  logic [1:0]  cfg_wm = 2'd0;
  logic        soft_clr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data, mem_wr_data, mem_rd_data;
  logic        mem_wr_en, mem_rd_en;
  logic [7:0]  mem_wr_addr, mem_rd_addr;
  logic        dma_wr_en = 1'b0, dma_rd_en = 1'b0;
  logic [3:0]  irq_en = 4'd0;
  logic        full_flag, empty_flag, ovf_flag, unf_flag, dma_wr_req, dma_rd_req, irq, clr_busy;

  logic [15:0] mem [256];
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  circ_buf_window dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_len(cfg_len), .cfg_wm(cfg_wm),
    .soft_clr(soft_clr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .dma_wr_en(dma_wr_en), .dma_rd_en(dma_rd_en), .irq_en(irq_en),
    .full_flag(full_flag), .empty_flag(empty_flag), .ovf_flag(ovf_flag), .unf_flag(unf_flag),
    .dma_wr_req(dma_wr_req), .dma_rd_req(dma_rd_req), .irq(irq), .clr_busy(clr_busy));

  always @(posedge clk) if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
  assign mem_rd_data = mem[mem_rd_addr];

  int m_base = 0, m_len = 8, m_wm = 0, m_cnt = 0, m_wp = 0, m_rp = 0;
  bit m_ovf = 0, m_unf = 0, m_clrq = 0;
  int m_rd = 0;
  logic [15:0] exp_mem [256];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_full();
    return (m_len - m_cnt) < (1 << m_wm);
  endfunction
  function automatic bit exp_empty();
    return m_cnt < (1 << m_wm);
  endfunction

  task automatic step(bit w, logic [15:0] d, bit r, bit c);
    bit aw, ar, f, e;
    int wa, ra;
    wr_en = w; wr_data = d; rd_en = r; soft_clr = c;
    #1;
    f = exp_full(); e = exp_empty();
    aw = w && !m_clrq && (m_cnt != m_len);
    ar = r && !m_clrq && (m_cnt != 0);
    wa = (m_base + m_wp) % 256;
    ra = (m_base + m_rp) % 256;
    chk("R4 full_flag", full_flag, f);
    chk("R5 empty_flag", empty_flag, e);
    chk("R6 ovf_flag", ovf_flag, m_ovf);
    chk("R7 unf_flag", unf_flag, m_unf);
    chk("R8 rd_data", rd_data, m_rd);
    chk("R9 clr_busy", clr_busy, m_clrq);
    chk("R10 dma_wr_req", dma_wr_req, dma_wr_en && !f);
    chk("R10 dma_rd_req", dma_rd_req, dma_rd_en && !e);
    chk("R11 irq", irq, (irq_en[0] && m_ovf) || (irq_en[1] && m_unf) ||
                        (irq_en[2] && !f) || (irq_en[3] && !e));
    chk("R2 R6 mem_wr_en", mem_wr_en, aw);
    chk("R7 R8 mem_rd_en", mem_rd_en, ar);
    if (aw) begin
      chk("R2 R3 mem_wr_addr", mem_wr_addr, wa);
      chk("R2 mem_wr_data", mem_wr_data, d);
    end
    if (ar) chk("R3 R8 mem_rd_addr", mem_rd_addr, ra);
    if (m_clrq) begin
      m_cnt = 0; m_wp = 0; m_rp = 0; m_ovf = 0; m_unf = 0;
    end else begin
      if (w && !aw) m_ovf = 1;
      if (r && !ar) m_unf = 1;
      if (aw) begin
        exp_mem[wa] = d;
        m_wp = (m_wp == m_len - 1) ? 0 : m_wp + 1;
      end
      if (ar) begin
        m_rd = exp_mem[ra];
        m_rp = (m_rp == m_len - 1) ? 0 : m_rp + 1;
      end
      m_cnt = m_cnt + int'(aw) - int'(ar);
    end
    m_clrq = c && !m_clrq;
    @(negedge clk);
  endtask

  task automatic reconfig(int b, int l, int wm);
    step(0, 16'h0, 0, 1);
    step(0, 16'h0, 0, 0);
    cfg_base = 8'(b); cfg_len = 8'(l); cfg_wm = 2'(wm);
    m_base = b; m_len = l; m_wm = wm;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = '0; exp_mem[i] = '0; end
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 ovf_flag", ovf_flag, 0);
    chk("R1 unf_flag", unf_flag, 0);
    chk("R1 clr_busy", clr_busy, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 empty_flag", empty_flag, 1);
    chk("R1 full_flag", full_flag, 0);
    @(negedge clk);

    for (int k = 0; k < 6; k++) begin
      int b, l, wm;
      case (k)
        0: begin b = 0;   l = 8;   wm = 0; end
        1: begin b = 250; l = 10;  wm = 1; end
        2: begin b = 100; l = 1;   wm = 0; end
        3: begin b = 17;  l = 5;   wm = 3; end
        4: begin b = 200; l = 60;  wm = 2; end
        default: begin b = 3; l = 255; wm = 3; end
      endcase
      reconfig(b, l, wm);
      dma_wr_en = 1'b1; dma_rd_en = 1'b1; irq_en = 4'(k + 3);
      // directed: fill past the end (R6), then drain past empty (R7)
      for (int i = 0; i <= l; i++) step(1, 16'($urandom), 0, 0);
      step(1, 16'hdead, 1, 0);
      for (int i = 0; i <= l; i++) step(0, 16'h0, 1, 0);
      // clear in the middle of traffic (R9)
      step(1, 16'h1234, 0, 1);
      step(1, 16'h5678, 1, 0);
      step(0, 16'h0, 0, 0);
      // random traffic with phased bias
      for (int i = 0; i < 400; i++) begin
        int bias;
        bias = ((i / 50) % 2 == 0) ? 75 : 25;
        dma_wr_en = 1'($urandom); dma_rd_en = 1'($urandom); irq_en = 4'($urandom);
        step(($urandom % 100) < bias, 16'($urandom), ($urandom % 100) < (100 - bias),
             ($urandom % 300) == 0);
      end
    end
    step(0, 16'h0, 0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule